// File: doc/BRIEF.md
# Keystream MAC Window Accumulator

This block builds an integrity tag from a message and a keystream. It keeps three consecutive keystream words as a 96-bit window, which is the concatenation {word0, word1, word2}. It also keeps a 32-bit tag register. Each accumulate command carries a 64-bit message word. For every set message bit, the block XORs into the tag the 32-bit slice of the window that starts at that bit's position. The scan takes a fixed number of positions per clock.

After the scan, the window slides. Word 0 takes the old word 2, and words 1 and 2 are then fetched, in that order, from an external keystream generator through a request/valid handshake. A start command clears the tag and fetches three fresh words into word 0, word 1 and word 2. A context port lets software save and restore the window and the tag. Key setup and the final XOR with the last keystream word belong to other blocks.

Top module: `mac_window_acc`

## Requirements
- R1: An accepted start (start_req high while idle) clears the tag and loads the next three keystream words into word 0, word 1 and word 2, in that order. Start takes precedence over a simultaneous accumulate command.
- R2: Message bit 63 is position 0 and message bit 0 is position 63. The slice at position p is bits [95-p : 64-p] of {word0, word1, word2}. Position 0 is therefore word 0, and position 32 is word 1.
- R3: The tag becomes its old value XOR every slice selected by the command. The tag carries over from one accumulate command to the next and is not cleared by them.
- R4: When an accumulate command completes, word 0 holds the old word 2. Word 1 and word 2 hold the next two keystream words, in that order.
- R5: ks_req is high only while the window is being refilled. A keystream word is consumed only in a cycle with ks_req and ks_valid both high. A start consumes exactly three words and an accumulate command exactly two, and ks_valid stalls stretch the refill.
- R6: done is a one-cycle pulse. It is raised in the cycle after the last refill word is taken, and the new window and tag are readable in that same cycle.
- R7: cmd_ready is low from the cycle after a command is accepted until done. A command presented meanwhile is held and accepted afterwards.
- R8: The context read select picks one of four values:
  - 0 gives {word0, word1}, with word 0 in bits 63:32.
  - 1 gives word 2 in bits 31:0, with zero above.
  - 2 gives the tag in bits 31:0, with zero above.
  - 3 gives zero.
  All of them read zero after reset.
- R9: A context write while idle updates the selected field, using the same select encoding as R8 (select 3 writes nothing). A context write while busy is ignored.
- R10: A message word of zero leaves the tag unchanged but still slides the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start: clear tag and fill the window |
| cmd_valid | input | 1 | Accumulate command valid |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_data | input | 2*WORD_W | Message word of the command |
| ks_req | output | 1 | Requesting a keystream word |
| ks_valid | input | 1 | Keystream word present |
| ks_word | input | WORD_W | Keystream word |
| done | output | 1 | Command finished pulse |
| ctx_we | input | 1 | Context write strobe |
| ctx_wsel | input | 2 | Context write select |
| ctx_wdata | input | 2*WORD_W | Context write data |
| ctx_rsel | input | 2 | Context read select |
| ctx_rdata | output | 2*WORD_W | Context read data |

## Verification
The bench drives message words with a single set bit at positions 0, 32 and 63. These show whether the slice is aligned to word 0, to word 1, or to the far end of word 2. A zero word separates window sliding from tag accumulation. An all-ones word and a mixed pattern, run with the keystream port stalling, exercise the full XOR reduction under a stretched refill. Restored context and the busy-time writes, held commands and restarts show whether state comes from the right source, checked against a bit-serial reference over a stored keystream sequence.

// File: rtl/macw_pkg.sv
`timescale 1ns/1ps
package macw_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_BPC    = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_FILL = 2'd2
    } macw_phase_e;

    // context select encoding shared by reads and writes
    typedef enum logic [1:0] {
        CTX_PAIR = 2'd0,
        CTX_HIGH = 2'd1,
        CTX_TAG  = 2'd2,
        CTX_NONE = 2'd3
    } macw_ctx_e;

    typedef enum logic [1:0] {
        SLOT_W0 = 2'd0,
        SLOT_W1 = 2'd1,
        SLOT_W2 = 2'd2
    } macw_slot_e;

    typedef struct packed {
        logic       scan;
        logic       scan_last;
        logic       take;
        macw_slot_e slot;
    } macw_ctl_t;

    function automatic macw_slot_e slot_after(macw_slot_e s);
        return macw_slot_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/macw_slice_xor.sv
`timescale 1ns/1ps
module macw_slice_xor #(
    parameter int unsigned W   = 32,
    parameter int unsigned BPC = 8
) (
    input  logic [3*W-1:0]              win,
    input  logic [BPC-1:0]              bits,
    input  logic [$clog2(2*W):0]        base,
    output logic [W-1:0]                part
);
    localparam int unsigned WIN_W = 3 * W;
    localparam int unsigned PW    = $clog2(2 * W) + 1;

    logic [W-1:0] term [BPC];

    for (genvar j = 0; j < BPC; j++) begin : g_pos
        logic [PW-1:0]    pos;
        logic [WIN_W-1:0] shifted;
        assign pos     = base + PW'(j);
        assign shifted = win << pos;
        assign term[j] = bits[BPC-1-j] ? shifted[WIN_W-1 -: W] : '0;
    end

    always_comb begin
        part = '0;
        for (int j = 0; j < BPC; j++) begin
            part = part ^ term[j];
        end
    end
endmodule

// File: rtl/macw_seq.sv
`timescale 1ns/1ps
module macw_seq
    import macw_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned BPC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_req,
    input  logic                 cmd_valid,
    input  logic                 ks_valid,
    output logic                 cmd_ready,
    output logic                 ks_req,
    output logic                 done,
    output logic                 busy,
    output macw_ctl_t            ctl,
    output logic [$clog2(2*W):0] base
);
    localparam int unsigned PW        = $clog2(2 * W) + 1;
    localparam int unsigned LAST_BASE = 2 * W - BPC;

    macw_phase_e   phase_q;
    macw_slot_e    slot_q;
    logic [PW-1:0] base_q;
    logic          done_q;
    logic          at_last;

    assign at_last = (base_q == PW'(LAST_BASE));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            slot_q  <= SLOT_W0;
            base_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_req) begin
                        phase_q <= PH_FILL;
                        slot_q  <= SLOT_W0;
                    end else if (cmd_valid) begin
                        phase_q <= PH_SCAN;
                        base_q  <= '0;
                    end
                end
                PH_SCAN: begin
                    if (at_last) begin
                        phase_q <= PH_FILL;
                        slot_q  <= SLOT_W1;
                    end else begin
                        base_q <= base_q + PW'(BPC);
                    end
                end
                PH_FILL: begin
                    if (ks_valid) begin
                        if (slot_q == SLOT_W2) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            slot_q <= slot_after(slot_q);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy          = (phase_q != PH_IDLE);
    assign cmd_ready     = !busy && !start_req;
    assign ks_req        = (phase_q == PH_FILL);
    assign done          = done_q;
    assign base          = base_q;
    assign ctl.scan      = (phase_q == PH_SCAN);
    assign ctl.scan_last = (phase_q == PH_SCAN) && at_last;
    assign ctl.take      = (phase_q == PH_FILL) && ks_valid;
    assign ctl.slot      = slot_q;
endmodule

// File: rtl/mac_window_acc.sv
`timescale 1ns/1ps
module mac_window_acc
    import macw_pkg::*;
#(
    parameter int unsigned WORD_W         = DEF_WORD_W,
    parameter int unsigned BITS_PER_CYCLE = DEF_BPC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_req,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [2*WORD_W-1:0]   cmd_data,
    output logic                  ks_req,
    input  logic                  ks_valid,
    input  logic [WORD_W-1:0]     ks_word,
    output logic                  done,
    input  logic                  ctx_we,
    input  logic [1:0]            ctx_wsel,
    input  logic [2*WORD_W-1:0]   ctx_wdata,
    input  logic [1:0]            ctx_rsel,
    output logic [2*WORD_W-1:0]   ctx_rdata
);
    localparam int unsigned MSG_W = 2 * WORD_W;
    localparam int unsigned PW    = $clog2(MSG_W) + 1;

    logic [WORD_W-1:0] w0_q, w1_q, w2_q, tag_q;
    logic [MSG_W-1:0]  msg_q;
    logic [WORD_W-1:0] part;
    logic [PW-1:0]     base;
    logic              busy;
    logic              ctx_ok;
    macw_ctl_t         ctl;
    macw_ctx_e         wsel;

    assign wsel   = macw_ctx_e'(ctx_wsel);
    assign ctx_ok = ctx_we && !busy;

    macw_seq #(.W(WORD_W), .BPC(BITS_PER_CYCLE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .cmd_valid (cmd_valid),
        .ks_valid  (ks_valid),
        .cmd_ready (cmd_ready),
        .ks_req    (ks_req),
        .done      (done),
        .busy      (busy),
        .ctl       (ctl),
        .base      (base)
    );

    macw_slice_xor #(.W(WORD_W), .BPC(BITS_PER_CYCLE)) u_slice (
        .win  ({w0_q, w1_q, w2_q}),
        .bits (msg_q[MSG_W-1 -: BITS_PER_CYCLE]),
        .base (base),
        .part (part)
    );

    // window words: refill, slide, context restore
    always_ff @(posedge clk) begin
        if (rst) begin
            w0_q <= '0;
            w1_q <= '0;
            w2_q <= '0;
        end else begin
            if (ctl.take) begin
                unique case (ctl.slot)
                    SLOT_W0: w0_q <= ks_word;
                    SLOT_W1: w1_q <= ks_word;
                    default: w2_q <= ks_word;
                endcase
            end
            if (ctl.scan_last) begin
                w0_q <= w2_q;
            end
            if (ctx_ok) begin
                unique case (wsel)
                    CTX_PAIR: begin
                        w0_q <= ctx_wdata[MSG_W-1:WORD_W];
                        w1_q <= ctx_wdata[WORD_W-1:0];
                    end
                    CTX_HIGH: w2_q <= ctx_wdata[WORD_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (start_req && !busy) begin
            tag_q <= '0;
        end else if (ctl.scan) begin
            tag_q <= tag_q ^ part;
        end else if (ctx_ok && wsel == CTX_TAG) begin
            tag_q <= ctx_wdata[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            msg_q <= cmd_data;
        end else if (ctl.scan) begin
            msg_q <= msg_q << BITS_PER_CYCLE;
        end
    end

    always_comb begin
        unique case (macw_ctx_e'(ctx_rsel))
            CTX_PAIR: ctx_rdata = {w0_q, w1_q};
            CTX_HIGH: ctx_rdata = {{WORD_W{1'b0}}, w2_q};
            CTX_TAG:  ctx_rdata = {{WORD_W{1'b0}}, tag_q};
            default:  ctx_rdata = '0;
        endcase
    end
endmodule

// File: rtl/macw_chk.sv
`timescale 1ns/1ps
module macw_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start_req,
    input logic         cmd_valid,
    input logic         cmd_ready,
    input logic         ks_req,
    input logic         ks_valid,
    input logic         done,
    input logic         busy,
    input logic         ctx_we,
    input logic [W-1:0] tag_q,
    input logic [W-1:0] w2_q
);
    assert_fill_excl_R5: assert property (@(posedge clk) disable iff (rst)
        ks_req |-> !cmd_ready);

    assert_done_after_take_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(ks_req && ks_valid));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_hold_off_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_start_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy) |=> (tag_q == '0));

    assert_tag_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        ks_req |=> $stable(tag_q));

    assert_idle_window_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctx_we) |=> $stable(w2_q));
endmodule

bind mac_window_acc macw_chk #(.W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .ks_req    (ks_req),
    .ks_valid  (ks_valid),
    .done      (done),
    .busy      (busy),
    .ctx_we    (ctx_we),
    .tag_q     (tag_q),
    .w2_q      (w2_q)
);

// File: tb/sim_mac_window_acc.sv
`timescale 1ns/1ps
module sim_mac_window_acc;
    localparam int W     = 32;
    localparam int BPC   = 8;
    localparam int STEPS = 2 * W / BPC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_data = '0;
    logic        ks_req;
    logic        ks_valid = 1'b0;
    logic [31:0] ks_word = '0;
    logic        done;
    logic        ctx_we = 1'b0;
    logic [1:0]  ctx_wsel = 2'd3;
    logic [63:0] ctx_wdata = '0;
    logic [1:0]  ctx_rsel = 2'd3;
    logic [63:0] ctx_rdata;

    always #2.5 clk = ~clk;

    mac_window_acc #(.WORD_W(W), .BITS_PER_CYCLE(BPC)) u0 (
        .clk(clk), .rst(rst), .start_req(start_req), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_data(cmd_data), .ks_req(ks_req),
        .ks_valid(ks_valid), .ks_word(ks_word), .done(done), .ctx_we(ctx_we),
        .ctx_wsel(ctx_wsel), .ctx_wdata(ctx_wdata), .ctx_rsel(ctx_rsel),
        .ctx_rdata(ctx_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    // keystream source
    logic [31:0] ks_mem [0:127];
    int ks_idx = 0;
    int hs_total = 0;
    int stall_mod = 1;
    int stall_cnt = 0;
    int req_while_ready = 0;

    always @(posedge clk) begin
        if (ks_req && ks_valid) begin
            ks_idx   <= ks_idx + 1;
            hs_total <= hs_total + 1;
        end
        if (ks_req && cmd_ready) req_while_ready <= req_while_ready + 1;
    end

    initial begin
        forever begin
            @(negedge clk);
            stall_cnt++;
            ks_word  = ks_mem[ks_idx];
            ks_valid = ks_req && ((stall_cnt % stall_mod) == 0);
        end
    end

    // reference model
    logic [31:0] m_w0 = '0, m_w1 = '0, m_w2 = '0, m_tag = '0;
    int m_ptr = 0;

    typedef struct packed {
        logic [31:0] tag;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] w2;
        logic [7:0]  hs;
    } exp_t;
    exp_t  exp_q [$];
    string rq_q  [$];

    function automatic logic [31:0] ref_slice(logic [31:0] a, logic [31:0] b,
                                               logic [31:0] c, int p);
        if (p == 0)       return a;
        else if (p < 32)  return (a << p) | (b >> (32 - p));
        else if (p == 32) return b;
        else              return (b << (p - 32)) | (c >> (64 - p));
    endfunction

    task automatic push_exp(input logic [7:0] hs, input string rq);
        exp_t e;
        e.tag = m_tag; e.w0 = m_w0; e.w1 = m_w1; e.w2 = m_w2; e.hs = hs;
        exp_q.push_back(e);
        rq_q.push_back(rq);
    endtask

    task automatic model_start(input string rq);
        m_tag = '0;
        m_w0 = ks_mem[m_ptr]; m_w1 = ks_mem[m_ptr+1]; m_w2 = ks_mem[m_ptr+2];
        m_ptr += 3;
        push_exp(8'd3, rq);
    endtask

    task automatic model_more(input logic [63:0] d, input string rq);
        for (int p = 0; p < 64; p++) begin
            if (d[63-p]) m_tag = m_tag ^ ref_slice(m_w0, m_w1, m_w2, p);
        end
        m_w0 = m_w2;
        m_w1 = ks_mem[m_ptr]; m_w2 = ks_mem[m_ptr+1];
        m_ptr += 2;
        push_exp(8'd2, rq);
    endtask

    // monitor: pops expected items when the design signals completion
    initial begin
        int hs_mark = 0;
        logic prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (done && prev_done) begin
                checks++; errors++;
                $display("FAIL R6 done wider than one cycle actual 1 expected 0");
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected done actual 1 expected 0");
                end else begin
                    exp_t  e;
                    string rq;
                    e  = exp_q.pop_front();
                    rq = rq_q.pop_front();
                    ctx_rsel = 2'd0; #0.2;
                    chk({rq, " R4 window pair"}, ctx_rdata, {e.w0, e.w1});
                    ctx_rsel = 2'd1; #0.2;
                    chk({rq, " R4 word2"}, ctx_rdata, {32'd0, e.w2});
                    ctx_rsel = 2'd2; #0.2;
                    chk({rq, " R3 tag"}, ctx_rdata, {32'd0, e.tag});
                    chk({rq, " R5 keystream words used"}, 64'(hs_total - hs_mark), 64'(e.hs));
                    hs_mark = hs_total;
                    ctx_rsel = 2'd3;
                end
            end
            prev_done = done;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_start(input string rq);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        start_req = 1'b1;
        model_start(rq);
        @(negedge clk);
        start_req = 1'b0;
        drain();
    endtask

    task automatic do_more(input logic [63:0] d, input string rq);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        model_more(d, rq);
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();
    endtask

    task automatic ctx_write(input logic [1:0] sel, input logic [63:0] v);
        @(negedge clk);
        ctx_we = 1'b1; ctx_wsel = sel; ctx_wdata = v;
        @(negedge clk);
        ctx_we = 1'b0; ctx_wsel = 2'd3;
    endtask

    task automatic ctx_read(input logic [1:0] sel, output logic [63:0] v);
        @(negedge clk);
        ctx_rsel = sel; #0.2;
        v = ctx_rdata;
        ctx_rsel = 2'd3;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not complete actual hung expected done");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        logic [31:0] x;
        int          n;
        x = 32'h1234_5678;
        for (int i = 0; i < 128; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            ks_mem[i] = x;
        end

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R7 reset ready", {63'd0, cmd_ready}, 64'd1);
        chk("R5 reset ks_req", {63'd0, ks_req}, 64'd0);
        chk("R6 reset done", {63'd0, done}, 64'd0);
        ctx_read(2'd0, v); chk("R8 reset pair", v, 64'd0);
        ctx_read(2'd2, v); chk("R8 reset tag", v, 64'd0);

        do_start("R1 start fill");
        do_more(64'h8000_0000_0000_0000, "R2 position 0");
        do_more(64'h0000_0000_8000_0000, "R2 position 32");
        do_more(64'h0000_0000_0000_0001, "R2 position 63");
        do_more(64'h0000_0000_0000_0000, "R10 zero word");
        do_more(64'hFFFF_FFFF_FFFF_FFFF, "R3 all ones");
        stall_mod = 3;
        do_more(64'hA5C3_0F96_1248_7E01, "R5 stalled refill");
        stall_mod = 1;

        // context restore while idle
        ctx_write(2'd0, 64'h0123_4567_89AB_CDEF);
        ctx_write(2'd1, 64'hFFFF_FFFF_DEAD_F00D);
        ctx_write(2'd2, 64'h0000_0000_1357_9BDF);
        ctx_write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        m_w0 = 32'h0123_4567; m_w1 = 32'h89AB_CDEF; m_w2 = 32'hDEAD_F00D; m_tag = 32'h1357_9BDF;
        ctx_read(2'd0, v); chk("R9 restore pair", v, 64'h0123_4567_89AB_CDEF);
        ctx_read(2'd1, v); chk("R9 restore word2", v, 64'h0000_0000_DEAD_F00D);
        ctx_read(2'd2, v); chk("R9 restore tag", v, 64'h0000_0000_1357_9BDF);
        ctx_read(2'd3, v); chk("R8 select 3 reads zero", v, 64'd0);
        do_more(64'h1111_0000_8888_0001, "R9 run from restored context");

        // write while busy is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_data = 64'h0F0F_F0F0_3C3C_C3C3;
        while (!cmd_ready) @(negedge clk);
        model_more(64'h0F0F_F0F0_3C3C_C3C3, "R9 busy write ignored");
        @(negedge clk);
        cmd_valid = 1'b0;
        ctx_we = 1'b1; ctx_wsel = 2'd2; ctx_wdata = 64'h0000_0000_DEAD_BEEF;
        @(negedge clk);
        ctx_wsel = 2'd0; ctx_wdata = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        ctx_we = 1'b0; ctx_wsel = 2'd3;
        drain();
        ctx_read(2'd2, v); chk("R9 tag after busy write", v, {32'd0, m_tag});

        // held command while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_data = 64'h8000_0001_0000_0000;
        while (!cmd_ready) @(negedge clk);
        model_more(64'h8000_0001_0000_0000, "R7 first of pair");
        @(negedge clk);
        cmd_data = 64'h0000_0000_FFFF_0000;
        n = 0;
        while (!cmd_ready) begin
            n++;
            @(negedge clk);
        end
        chk("R7 ready low until done", {63'd0, (n >= STEPS + 2)}, 64'd1);
        model_more(64'h0000_0000_FFFF_0000, "R7 held command");
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();

        // restart clears a nonzero tag; start beats a simultaneous command
        @(negedge clk);
        start_req = 1'b1; cmd_valid = 1'b1; cmd_data = 64'hFFFF_FFFF_FFFF_FFFF;
        model_start("R1 restart over command");
        @(negedge clk);
        start_req = 1'b0; cmd_valid = 1'b0;
        drain();
        ctx_read(2'd2, v); chk("R1 tag cleared by start", v, 64'd0);

        chk("R5 ks_req never with ready", 64'(req_while_ready), 64'd0);
        chk("R6 all results seen", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule